// File: doc/BRIEF.md
# Divider Setting Capture Unit

This block holds the loop-divider value (M), the post-divider code (N) and a two-bit test selector (T) for a clock synthesizer. Two front ends can write these registers. One is a parallel pin bus with an active-low strobe. The other is a three-wire serial port made of a data line, a shift clock and a load line. Both paths have a transparent phase, in which the target registers follow their source, and a latched phase, in which the registers hold. The test selector can be written only through the serial port.

All control lines are asynchronous to the system clock. Each one passes through a two-stage synchronizer, and the block then detects edges on the synchronized copies. At most one edge of each line is acted on per system clock. The M and N pins are not synchronized: they are sampled directly, but only while the synchronized strobe is low.

The block exposes three more outputs:
- the oldest bit of the shift register;
- a flag that is set once a serial load has taken place;
- a flag that reports whether the held M lies in the range where the loop can lock, which is 8 to 28 inclusive.

Top module: `divcfg_loader`

## Requirements
- R1: After reset, M, N and T are all zero, the serial-mode flag is 0 and the shift tap is 0.
- R2: While the synchronized parallel strobe is low, M and N follow the par_m and par_n pins on every clock.
- R3: After the strobe returns high, M and N hold their last captured values, and later changes on the pins have no effect.
- R4: While the strobe is high, each rising edge of the shift clock shifts the data bit into bit 0 of a 14-bit shift register. shift_tap shows bit 13. Shifting alone, with the load line low, leaves M, N and T unchanged.
- R5: A rising edge on the load line copies the shift register into the target registers. T is bits 13:12, bit 11 is an unused slot, N is bits 10:9 and M is bits 8:0, so the bit order on the wire is T1, T0, unused, N1, N0, M8 down to M0. M is plain binary.
- R6: After the load line falls, M, N and T hold while further bits are shifted in.
- R7: While the load line stays high, every rising edge of the shift clock also moves the newly shifted contents into M, N and T.
- R8: The parallel path never changes T.
- R9: While the strobe is low, the shift clock has no effect on the shift register.
- R10: serial_mode is set by a serial load edge and is cleared while the strobe is low.
- R11: m_lock_ok is 1 exactly when M is between 8 and 28 inclusive.
- R12: A change on a control line acts on the third rising clock edge after it. A change on the M or N pins reaches the outputs on the next edge while the strobe is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_m | input | 9 | Parallel M value |
| par_n | input | 2 | Parallel N code |
| par_load_n | input | 1 | Parallel strobe, active low |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial load line |
| div_m | output | 9 | Held M value |
| div_n | output | 2 | Held N code |
| test_sel | output | 2 | Held test selector |
| shift_tap | output | 1 | Bit 13 of the shift register |
| serial_mode | output | 1 | Serial load has taken effect |
| m_lock_ok | output | 1 | M lies in the lock range |

## Verification
The checks assume each level of the control lines is held for more than one system clock, so that the synchronizers see every edge. They also assume the M and N pins stay stable for at least the synchronizer depth after the strobe rises. The stimulus holds every level of the shift clock, the load line and the strobe for four clocks, and it changes the pins only after the strobe's rise has settled. Under these conditions the registered effects line up with the edges seen on the synchronized lines. A behavioural model in the bench predicts every output on every clock.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
    // which source writes the target registers in a given cycle
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_PAR  = 2'd1,
        SRC_SER  = 2'd2
    } src_e;

    localparam int SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign stg_d[g] = d;
        end else begin : g_next
            assign stg_d[g] = stg_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/divcfg_shift.sv
module divcfg_shift #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] sh_d,
    output logic [W-1:0] sh_q
);
    always_comb begin
        sh_d = sh_q;
        if (shift_en) sh_d = {sh_q[W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // R4
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sh_q[0] == $past(din)) && (sh_q[W-1:1] == $past(sh_q[W-2:0])));

    // R9
    shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sh_q));
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
    import divcfg_pkg::*;
#(
    parameter int M_W         = 9,
    parameter int N_W         = 2,
    parameter int T_W         = 2,
    parameter int NULL_W      = 1,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF,
    parameter int LOCK_MIN    = 8,
    parameter int LOCK_MAX    = 28
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           par_load_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    output logic [M_W-1:0] div_m,
    output logic [N_W-1:0] div_n,
    output logic [T_W-1:0] test_sel,
    output logic           shift_tap,
    output logic           serial_mode,
    output logic           m_lock_ok
);
    localparam int FRAME_W = T_W + NULL_W + N_W + M_W;
    localparam int N_LSB   = M_W;
    localparam int T_LSB   = M_W + N_W + NULL_W;
    localparam int CTL_W   = 4;
    localparam int PL_I    = 0;
    localparam int SD_I    = 1;
    localparam int SC_I    = 2;
    localparam int SL_I    = 3;
    localparam logic [CTL_W-1:0] CTL_RST = CTL_W'(1 << PL_I);
    localparam logic [M_W-1:0] LOCK_LO = M_W'(LOCK_MIN);
    localparam logic [M_W-1:0] LOCK_HI = M_W'(LOCK_MAX);

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
        logic [T_W-1:0] t;
        logic           mode;
        logic           sc_prev;
        logic           sl_prev;
    } state_t;

    state_t state_d, state_q;
    src_e   src;

    logic [CTL_W-1:0]   ctl_s;
    logic               pl_s, sd_s, sc_s, sl_s;
    logic               sc_rise, sl_rise, shift_en;
    logic [FRAME_W-1:0] sh_d, sh_q;

    divcfg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_load, ser_clk, ser_data, par_load_n}),
        .q     (ctl_s)
    );

    assign pl_s = ctl_s[PL_I];
    assign sd_s = ctl_s[SD_I];
    assign sc_s = ctl_s[SC_I];
    assign sl_s = ctl_s[SL_I];

    assign sc_rise  = sc_s & ~state_q.sc_prev;
    assign sl_rise  = sl_s & ~state_q.sl_prev;
    assign shift_en = pl_s & sc_rise;

    divcfg_shift #(.W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (sd_s),
        .sh_d     (sh_d),
        .sh_q     (sh_q)
    );

    always_comb begin
        state_d         = state_q;
        state_d.sc_prev = sc_s;
        state_d.sl_prev = sl_s;

        if (!pl_s)                           src = SRC_PAR;
        else if (sl_rise || (sc_rise && sl_s)) src = SRC_SER;
        else                                 src = SRC_HOLD;

        case (src)
            SRC_PAR: begin
                state_d.m    = par_m;
                state_d.n    = par_n;
                state_d.mode = 1'b0;
            end
            SRC_SER: begin
                state_d.m = sh_d[M_W-1:0];
                state_d.n = sh_d[N_LSB +: N_W];
                state_d.t = sh_d[T_LSB +: T_W];
            end
            default: ;
        endcase

        if (pl_s && sl_rise) state_d.mode = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign div_m       = state_q.m;
    assign div_n       = state_q.n;
    assign test_sel    = state_q.t;
    assign serial_mode = state_q.mode;
    assign shift_tap   = sh_q[FRAME_W-1];
    assign m_lock_ok   = (state_q.m >= LOCK_LO) && (state_q.m <= LOCK_HI);

    // R8
    t_par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_s |=> $stable(test_sel));

    // R10
    mode_par_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_s |=> !serial_mode);

    // R6
    latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_s && !sl_s) |=> ($stable(div_m) && $stable(div_n) && $stable(test_sel)));

    // R9
    shift_par_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_s |=> $stable(shift_tap));
endmodule

// File: tb/divcfg_loader_test.sv
`timescale 1ns/1ps
module divcfg_loader_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic       par_load_n = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_load = 1'b0;
    logic [8:0] div_m;
    logic [1:0] div_n;
    logic [1:0] test_sel;
    logic       shift_tap, serial_mode, m_lock_ok;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    divcfg_loader uut (
        .clk(clk), .rst_n(rst_n), .par_m(par_m), .par_n(par_n),
        .par_load_n(par_load_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .div_m(div_m), .div_n(div_n), .test_sel(test_sel),
        .shift_tap(shift_tap), .serial_mode(serial_mode), .m_lock_ok(m_lock_ok)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // behavioural reference: delayed samples of the control lines in queues
    int pl_h[$] = '{1, 1, 1};
    int sc_h[$] = '{0, 0, 0};
    int sl_h[$] = '{0, 0, 0};
    int sd_h[$] = '{0, 0, 0};
    int mm = 0, mn = 0, mt = 0, msh = 0, mmode = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            pl_h = '{1, 1, 1}; sc_h = '{0, 0, 0}; sl_h = '{0, 0, 0}; sd_h = '{0, 0, 0};
            mm = 0; mn = 0; mt = 0; msh = 0; mmode = 0;
        end else begin
            int pls, scs, scp, sls, slp, sds, nsh;
            bit crise, lrise;
            pls = pl_h[1]; scs = sc_h[1]; scp = sc_h[2];
            sls = sl_h[1]; slp = sl_h[2]; sds = sd_h[1];
            crise = (scs == 1) && (scp == 0);
            lrise = (sls == 1) && (slp == 0);
            if (pls == 0) begin
                mm = par_m; mn = par_n; mmode = 0;
            end else begin
                nsh = msh;
                if (crise) nsh = ((msh * 2) + sds) % 16384;
                if (lrise || (crise && sls == 1)) begin
                    mt = nsh / 4096; mn = (nsh / 512) % 4; mm = nsh % 512;
                end
                if (lrise) mmode = 1;
                msh = nsh;
            end
            void'(pl_h.pop_back()); pl_h.push_front(par_load_n);
            void'(sc_h.pop_back()); sc_h.push_front(ser_clk);
            void'(sl_h.pop_back()); sl_h.push_front(ser_load);
            void'(sd_h.pop_back()); sd_h.push_front(ser_data);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R12 model div_m", div_m, mm);
            chk("R12 model div_n", div_n, mn);
            chk("R12 model test_sel", test_sel, mt);
            chk("R12 model shift_tap", shift_tap, msh / 8192);
            chk("R12 model serial_mode", serial_mode, mmode);
            chk("R12 model m_lock_ok", m_lock_ok, (mm >= 8 && mm <= 28) ? 1 : 0);
        end
    end

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        ser_data = b; ser_clk = 1'b0; waitn(4);
        ser_clk = 1'b1; waitn(4);
        ser_clk = 1'b0; waitn(4);
    endtask

    task automatic send_frame(input int fr);
        for (int i = 13; i >= 0; i--) send_bit(fr[i]);
    endtask

    int fr1, fr2, sh;

    initial begin
        waitn(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 div_m", div_m, 0); chk("R1 div_n", div_n, 0);
        chk("R1 test_sel", test_sel, 0); chk("R1 serial_mode", serial_mode, 0);
        chk("R1 shift_tap", shift_tap, 0);
        waitn(2);

        // R12 exact latency and R2 pass-through
        par_m = 9'd20; par_n = 2'd2; par_load_n = 1'b0;
        waitn(2); chk("R12 before third edge", div_m, 0);
        waitn(1); chk("R12 third edge", div_m, 20); chk("R2 div_n", div_n, 2);
        chk("R11 m=20", m_lock_ok, 1);
        par_m = 9'd7;  waitn(2); chk("R2 follow", div_m, 7); chk("R11 m=7", m_lock_ok, 0);
        par_m = 9'd8;  waitn(2); chk("R11 m=8", m_lock_ok, 1);
        par_m = 9'd28; waitn(2); chk("R11 m=28", m_lock_ok, 1);
        par_m = 9'd29; waitn(2); chk("R11 m=29", m_lock_ok, 0);

        // R3 freeze
        par_m = 9'd25; par_n = 2'd1; waitn(4);
        par_load_n = 1'b1; waitn(4);
        par_m = 9'd100; par_n = 2'd3; waitn(4);
        chk("R3 div_m held", div_m, 25); chk("R3 div_n held", div_n, 1);

        // R4 shift without load
        fr1 = (2 << 12) | (1 << 9) | 17;
        send_frame(fr1);
        chk("R4 div_m untouched", div_m, 25); chk("R4 test_sel untouched", test_sel, 0);
        chk("R4 tap is T1", shift_tap, 1);

        // R5 load edge
        ser_load = 1'b1; waitn(4);
        chk("R5 div_m", div_m, 17); chk("R5 div_n", div_n, 1); chk("R5 test_sel", test_sel, 2);
        chk("R10 mode set", serial_mode, 1);

        // R6 latched after fall
        ser_load = 1'b0; waitn(4);
        fr2 = (1 << 12) | (3 << 9) | 9;
        send_frame(fr2);
        chk("R6 div_m held", div_m, 17); chk("R6 test_sel held", test_sel, 2);

        // R7 transparent while load high
        ser_load = 1'b1; waitn(4);
        chk("R5 second frame m", div_m, 9); chk("R5 second frame t", test_sel, 1);
        send_bit(1'b1);
        sh = ((fr2 * 2) + 1) % 16384;
        chk("R7 div_m", div_m, sh % 512); chk("R7 div_n", div_n, (sh / 512) % 4);
        chk("R7 test_sel", test_sel, sh / 4096);

        // R9 shift clock ignored during parallel strobe, R8 T kept, R10 cleared
        ser_load = 1'b0; waitn(4);
        par_m = 9'd12; par_n = 2'd0; par_load_n = 1'b0; waitn(4);
        send_bit(1'b0); send_bit(1'b0);
        chk("R9 tap stable", shift_tap, sh / 8192);
        chk("R8 test_sel kept", test_sel, sh / 4096);
        chk("R10 mode cleared", serial_mode, 0);
        chk("R2 div_m", div_m, 12);
        par_load_n = 1'b1; waitn(4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule